// File: doc/BRIEF.md
# Descriptor-Chained Bus-Master DMA Engine

This engine moves sector data between system memory and a disk drive's sector stream. It starts once the drive's command logic has entered its DMA data phase. A single start pulse supplies the address of a descriptor table in memory, the transfer direction, the command's sector count and the first logical block address. The engine then works through the table one entry at a time. Each entry is fetched over a memory port, and the region it describes is moved as a series of bus bursts, none of which crosses a page boundary. After the entry flagged as last has been moved, the engine reports completion to the command logic with a status code.

The memory port is a request/grant interface with at most one transaction in flight. If the bus does not grant a request, the engine drops the request, waits a fixed back-off time and retries the same access. Before the first burst of each region the engine waits a modelled media latency. An abort from the command logic ends a transfer at once with an error status. The media itself and the drive's register state machine are outside this block.

Top module: `prd_dma_engine`

## Requirements
- R1: A `start` pulse while idle makes the engine request, on the next cycle, an 8-byte descriptor read (`mem_fetch`=1, `mem_wr`=0) at `table_base` with its two low bits forced to zero. A `start` pulse while busy is ignored.
- R2: A descriptor returns on `mem_rdata` in this layout: bits [31:0] hold the region base, bits [47:32] hold the byte count, and bit 63 marks the last entry. Bit 32 of the count is ignored, and a count of 0 means 65536 bytes. The table pointer advances by 8 after each fetch. No further fetch is issued after the entry marked as last.
- R3: A region is moved in bursts of min(bytes left, bytes to the next page boundary). Every burst therefore stays within one page of 2^PAGE_W bytes. The burst lengths add up to the descriptor's count.
- R4: With `disk_write`=1 the bursts read memory (`mem_wr`=0). With `disk_write`=0 they write memory (`mem_wr`=1). Descriptor fetches are always reads.
- R5: A request that is not granted in the cycle it is raised is dropped for exactly BACKOFF cycles. It is then raised again with the same address.
- R6: Between the cycle in which a descriptor fetch completes and the first burst request for that region, exactly DISK_DELAY + count/512 + 1 cycles pass with the request low.
- R7: `lba` equals `start_lba` plus the number of whole 512-byte sectors moved since start. The command length is `sec_count` × 512 bytes, and a `sec_count` of 0 means 256 sectors.
- R8: When the last region finishes and the moved byte total equals the command length, `done` pulses for one cycle with `status`=0.
- R9: A burst that would exceed the command's remaining bytes is not issued. In that case, or when the last region ends with bytes still owed, the engine finishes with `status`=2.
- R10: A region whose end would pass the top of the 32-bit address space (base + count ≥ 2^32) issues no burst. The engine finishes with `status`=3.
- R11: `abort` while busy makes the engine idle and pulses `done` with `status`=1 on the next cycle. `abort` while idle produces no `done`.
- R12: After a grant, no new request is raised until `mem_done` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch pulse from the command logic |
| table_base | input | 32 | Descriptor table address; bits 1:0 ignored |
| disk_write | input | 1 | 1 = command writes the disk (engine reads memory) |
| sec_count | input | 8 | Sectors in the command; 0 means 256 |
| start_lba | input | 32 | First logical block address of the command |
| abort | input | 1 | Cancel the running transfer |
| mem_req | output | 1 | Memory access request |
| mem_gnt | input | 1 | Grant, sampled in the cycle `mem_req` is high |
| mem_fetch | output | 1 | Request is a descriptor fetch |
| mem_wr | output | 1 | Request writes memory |
| mem_addr | output | 32 | Request byte address |
| mem_len | output | 17 | Request byte length |
| mem_done | input | 1 | Granted access completed |
| mem_rdata | input | 64 | Descriptor contents, valid with `mem_done` after a fetch |
| lba | output | 32 | Current sector address |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 aborted, 2 byte count mismatch, 3 address wrap |

## Verification
The assertions take the memory side to be well behaved. `mem_gnt` is assumed to matter only in a cycle where `mem_req` is high. Exactly one `mem_done` is assumed to follow each grant, and none to arrive otherwise. `start` is assumed to come only while the engine is idle. The stimulus keeps within these limits in three ways. Its memory responder raises the grant only in reaction to a request it has seen. It returns the single completion one cycle after granting. It issues each new start only after the previous transfer has signalled `done`.

// File: rtl/prd_dma_engine.sv
module prd_dma_engine #(
  parameter int PAGE_W     = 12,
  parameter int DISK_DELAY = 4,
  parameter int BACKOFF    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] table_base,
  input  logic        disk_write,
  input  logic [7:0]  sec_count,
  input  logic [31:0] start_lba,
  input  logic        abort,
  output logic        mem_req,
  input  logic        mem_gnt,
  output logic        mem_fetch,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [16:0] mem_len,
  input  logic        mem_done,
  input  logic [63:0] mem_rdata,
  output logic [31:0] lba,
  output logic        done,
  output logic [1:0]  status
);
  localparam int PAGE  = 1 << PAGE_W;
  localparam int TOT_W = 18;
  localparam int CNT_W = $clog2(DISK_DELAY + BACKOFF + 130) + 1;
  localparam logic [1:0] ST_OK = 2'd0, ST_ABORT = 2'd1, ST_COUNT = 2'd2, ST_WRAP = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FWAIT, S_LAT, S_XFER, S_XWAIT, S_BACK} state_t;

  state_t             st;
  logic [31:0]        ptr, d_addr, lba_base;
  logic [16:0]        d_rem;
  logic               d_eot, to_mem, back_fetch;
  logic [TOT_W-1:0]   total, moved;
  logic [CNT_W-1:0]   cnt;

  logic [15:0]        raw_cnt;
  logic [16:0]        dcount, chunk;
  logic [PAGE_W:0]    page_left;
  logic [TOT_W-1:0]   cmd_left;
  logic               desc_wrap, overrun;
  logic               unused_bits;

  assign raw_cnt   = {mem_rdata[47:33], 1'b0};
  assign dcount    = (raw_cnt == 16'd0) ? 17'h10000 : {1'b0, raw_cnt};
  assign desc_wrap = (33'(mem_rdata[31:0]) + 33'(dcount)) > 33'h0_FFFF_FFFF;
  assign page_left = (PAGE_W+1)'(PAGE) - (PAGE_W+1)'(d_addr[PAGE_W-1:0]);
  assign chunk     = (d_rem < 17'(page_left)) ? d_rem : 17'(page_left);
  assign cmd_left  = total - moved;
  assign overrun   = TOT_W'(chunk) > cmd_left;
  assign unused_bits = ^{mem_rdata[62:48], mem_rdata[32], table_base[1:0]};

  assign mem_fetch = (st == S_FETCH);
  assign mem_req   = mem_fetch || (st == S_XFER && !overrun);
  assign mem_wr    = !mem_fetch && to_mem;
  assign mem_addr  = mem_fetch ? ptr : d_addr;
  assign mem_len   = mem_fetch ? 17'd8 : chunk;
  assign lba       = lba_base + 32'(moved[TOT_W-1:9]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; d_addr <= '0; lba_base <= '0; d_rem <= '0;
      d_eot <= 1'b0; to_mem <= 1'b0; back_fetch <= 1'b0; total <= '0;
      moved <= '0; cnt <= '0; done <= 1'b0; status <= ST_OK;
    end else begin
      done <= 1'b0;
      if (abort && st != S_IDLE) begin
        st <= S_IDLE; done <= 1'b1; status <= ST_ABORT;
      end else begin
        case (st)
          S_IDLE: if (start) begin
            ptr      <= {table_base[31:2], 2'b00};
            total    <= (sec_count == 8'd0) ? TOT_W'(256) << 9 : TOT_W'(sec_count) << 9;
            moved    <= '0;
            lba_base <= start_lba;
            to_mem   <= !disk_write;
            st       <= S_FETCH;
          end
          S_FETCH: begin
            if (mem_gnt) st <= S_FWAIT;
            else begin st <= S_BACK; back_fetch <= 1'b1; cnt <= CNT_W'(BACKOFF - 1); end
          end
          S_FWAIT: if (mem_done) begin
            ptr <= ptr + 32'd8;
            if (desc_wrap) begin
              st <= S_IDLE; done <= 1'b1; status <= ST_WRAP;
            end else begin
              d_addr <= mem_rdata[31:0];
              d_rem  <= dcount;
              d_eot  <= mem_rdata[63];
              cnt    <= CNT_W'(DISK_DELAY) + CNT_W'(dcount[16:9]);
              st     <= S_LAT;
            end
          end
          S_LAT: begin
            if (cnt == '0) st <= S_XFER;
            else cnt <= cnt - 1'b1;
          end
          S_XFER: begin
            if (overrun) begin st <= S_IDLE; done <= 1'b1; status <= ST_COUNT; end
            else if (mem_gnt) st <= S_XWAIT;
            else begin st <= S_BACK; back_fetch <= 1'b0; cnt <= CNT_W'(BACKOFF - 1); end
          end
          S_XWAIT: if (mem_done) begin
            d_addr <= d_addr + 32'(chunk);
            d_rem  <= d_rem - chunk;
            moved  <= moved + TOT_W'(chunk);
            if (d_rem != chunk) st <= S_XFER;
            else if (!d_eot) st <= S_FETCH;
            else begin
              st <= S_IDLE; done <= 1'b1;
              status <= (cmd_left == TOT_W'(chunk)) ? ST_OK : ST_COUNT;
            end
          end
          S_BACK: begin
            if (cnt == '0) st <= back_fetch ? S_FETCH : S_XFER;
            else cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_first_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start) |=> (mem_req && mem_fetch && mem_addr[1:0] == 2'b00 && mem_len == 17'd8));

  assert_no_page_cross_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_fetch) |-> ((18'(mem_addr[PAGE_W-1:0]) + 18'(mem_len)) <= 18'(PAGE)));

  assert_fetch_is_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_fetch) |-> !mem_wr);

  assert_backoff_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && !abort) |=> !mem_req);

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_abort_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && abort) |=> (done && status == ST_ABORT));

  assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && abort) |=> !done);

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_gnt) |=> !mem_req);

endmodule

// File: tb/tb_prd_dma_engine.sv
`timescale 1ns/1ps
module tb_prd_dma_engine;
  localparam int PW = 8;
  localparam int PG = 256;
  localparam int DD = 2;
  localparam int BO = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, disk_write = 1'b0, abort = 1'b0;
  logic mem_gnt = 1'b0, mem_done = 1'b0;
  logic [31:0] table_base = '0, start_lba = '0;
  logic [7:0]  sec_count = '0;
  logic [63:0] mem_rdata = '0;
  logic        mem_req, mem_fetch, mem_wr, done;
  logic [31:0] mem_addr, lba;
  logic [16:0] mem_len;
  logic [1:0]  status;

  prd_dma_engine #(.PAGE_W(PW), .DISK_DELAY(DD), .BACKOFF(BO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .table_base(table_base),
    .disk_write(disk_write), .sec_count(sec_count), .start_lba(start_lba),
    .abort(abort), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_fetch(mem_fetch),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_len(mem_len), .mem_done(mem_done),
    .mem_rdata(mem_rdata), .lba(lba), .done(done), .status(status));

  always #2 clk = ~clk;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [31:0] dbase [8];
  logic [15:0] dcnt [8];
  logic        deot [8];
  int fidx, moved, e_rem, lat_exp, fdone_cyc, refuse_cyc, busy_mode = 0, nbursts;
  logic [31:0] exp_ptr, e_addr, refuse_addr, cur_slba;
  logic        cur_dw;
  bit lat_pending = 0, retry_pending = 0, outstanding = 0, pend = 0, done_seen = 0;
  logic [63:0] pend_data;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin : responder
    int exp_len, page_left, eff;
    bit retry;
    forever begin
      @(negedge clk);
      cyc++;
      if (outstanding && mem_req) chk(1'b0, "R12 request while one is outstanding", 1, 0);
      mem_done = 1'b0;
      if (pend) begin pend = 0; outstanding = 0; mem_done = 1'b1; mem_rdata = pend_data; end
      if (done) done_seen = 1;
      mem_gnt = 1'b0;
      if (mem_req && rst_n) begin
        retry = retry_pending;
        if (retry) begin
          chk(cyc - refuse_cyc == BO + 1, "R5 back-off gap", cyc - refuse_cyc, BO + 1);
          chk(mem_addr == refuse_addr, "R5 retry address", mem_addr, refuse_addr);
        end
        retry_pending = 0;
        if (!mem_fetch && lat_pending) begin
          chk(cyc - fdone_cyc == lat_exp, "R6 first burst latency", cyc - fdone_cyc, lat_exp);
          lat_pending = 0;
        end
        if (busy_mode != 0 && !retry) begin
          retry_pending = 1; refuse_cyc = cyc; refuse_addr = mem_addr;
        end else begin
          mem_gnt = 1'b1; outstanding = 1; pend = 1;
          if (mem_fetch) begin
            chk(mem_addr == exp_ptr, "R2 descriptor pointer", mem_addr, exp_ptr);
            chk(mem_len == 17'd8, "R1 fetch length", mem_len, 8);
            chk(!mem_wr, "R4 fetch is a read", mem_wr, 0);
            pend_data = {deot[fidx & 7], 15'd0, dcnt[fidx & 7], dbase[fidx & 7]};
            eff = ((dcnt[fidx & 7] & 16'hFFFE) == 16'd0) ? 65536 : int'(dcnt[fidx & 7] & 16'hFFFE);
            e_addr = dbase[fidx & 7]; e_rem = eff;
            lat_exp = DD + eff / 512 + 2; lat_pending = 1; fdone_cyc = cyc + 1;
            fidx++; exp_ptr = exp_ptr + 32'd8;
          end else begin
            page_left = PG - int'(e_addr % PG);
            exp_len = (e_rem < page_left) ? e_rem : page_left;
            chk(mem_addr == e_addr, "R3 burst address", mem_addr, e_addr);
            chk(int'(mem_len) == exp_len, "R3 burst length", mem_len, exp_len);
            chk(mem_wr == !cur_dw, "R4 burst direction", mem_wr, !cur_dw);
            chk(lba == cur_slba + 32'(moved / 512), "R7 sector address", lba, cur_slba + 32'(moved / 512));
            e_addr = e_addr + 32'(exp_len); e_rem -= exp_len; moved += exp_len; nbursts++;
          end
        end
      end
    end
  end

  task automatic launch(input logic [31:0] ta, input logic dw, input logic [7:0] sc, input logic [31:0] slba);
    fidx = 0; exp_ptr = ta & 32'hFFFF_FFFC; moved = 0; nbursts = 0; done_seen = 0;
    lat_pending = 0; retry_pending = 0; cur_slba = slba; cur_dw = dw;
    @(negedge clk);
    start = 1'b1; table_base = ta; disk_write = dw; sec_count = sc; start_lba = slba;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(input logic [31:0] ta, input logic dw, input logic [7:0] sc, input logic [31:0] slba,
                     input logic [1:0] exp_st, input int exp_moved, input int exp_fetch, input string tag);
    launch(ta, dw, sc, slba);
    for (int i = 0; i < 60000 && !done_seen; i++) @(negedge clk);
    chk(done_seen, {tag, " done seen"}, done_seen, 1);
    chk(status == exp_st, {tag, " status"}, status, exp_st);
    chk(moved == exp_moved, {tag, " bytes moved (R3)"}, moved, exp_moved);
    chk(fidx == exp_fetch, {tag, " descriptors fetched (R2)"}, fidx, exp_fetch);
    chk(lba == slba + 32'(exp_moved / 512), {tag, " final sector address (R7)"}, lba, slba + 32'(exp_moved / 512));
    @(negedge clk);
    chk(!done, {tag, " done is one cycle (R8)"}, done, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    repeat (5) @(negedge clk);
    chk(!mem_req && !done && status == 2'd0, "R8 reset state", {mem_req, done, status}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    dbase[0] = 32'h0000_1000; dcnt[0] = 16'd1024; deot[0] = 1'b1;
    run(32'h0000_8003, 1'b1, 8'd2, 32'd100, 2'd0, 1024, 1, "R8 single region");

    dbase[0] = 32'h0000_10F0; dcnt[0] = 16'd513; deot[0] = 1'b0;
    dbase[1] = 32'h0000_2000; dcnt[1] = 16'd256; deot[1] = 1'b0;
    dbase[2] = 32'h0000_21C2; dcnt[2] = 16'd256; deot[2] = 1'b1;
    busy_mode = 1;
    run(32'h0000_9000, 1'b0, 8'd2, 32'd7, 2'd0, 1024, 3, "R2 chained table with back-off R5");
    busy_mode = 0;

    for (int off = 0; off < 256; off += 2) begin
      dbase[0] = 32'h0000_3000 + 32'(off); dcnt[0] = 16'd512; deot[0] = 1'b1;
      busy_mode = (off >> 1) & 1;
      run(32'h0000_0800, 1'((off >> 2) & 1), 8'd1, 32'(off), 2'd0, 512, 1, "R3 offset sweep");
    end
    busy_mode = 0;

    dbase[0] = 32'h0004_0000; dcnt[0] = 16'd0; deot[0] = 1'b1;
    run(32'h0000_A000, 1'b1, 8'd128, 32'd9, 2'd0, 65536, 1, "R2 zero count is 65536");

    dbase[0] = 32'h0010_0000; dcnt[0] = 16'd0; deot[0] = 1'b0;
    dbase[1] = 32'h0020_0000; dcnt[1] = 16'd1; deot[1] = 1'b1;
    run(32'h0000_B000, 1'b0, 8'd0, 32'd1000, 2'd0, 131072, 2, "R7 sector count 0 is 256");

    dbase[0] = 32'h0000_5000; dcnt[0] = 16'd1024; deot[0] = 1'b1;
    run(32'h0000_C000, 1'b1, 8'd1, 32'd50, 2'd2, 512, 1, "R9 overrun");

    dbase[0] = 32'h0000_5000; dcnt[0] = 16'd512; deot[0] = 1'b1;
    run(32'h0000_C000, 1'b0, 8'd2, 32'd50, 2'd2, 512, 1, "R9 underrun");

    dbase[0] = 32'hFFFF_FF00; dcnt[0] = 16'd256; deot[0] = 1'b1;
    run(32'h0000_D000, 1'b1, 8'd1, 32'd0, 2'd3, 0, 1, "R10 wrap");
    chk(nbursts == 0, "R10 no burst on wrap", nbursts, 0);

    dbase[0] = 32'hFFFF_FC00; dcnt[0] = 16'd512; deot[0] = 1'b1;
    run(32'h0000_D000, 1'b0, 8'd1, 32'd3, 2'd0, 512, 1, "R10 top of space without wrap");

    dbase[0] = 32'h0000_1000; dcnt[0] = 16'd0; deot[0] = 1'b1;
    launch(32'h0000_E000, 1'b1, 8'd128, 32'd0);
    for (int i = 0; i < 100 && fidx == 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    chk(done && status == 2'd1, "R11 abort while busy", {done, status}, 3'b101);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!mem_req, "R11 idle after abort", mem_req, 0);
    end
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(!done, "R11 abort while idle ignored", done, 0);
      @(negedge clk);
    end

    dbase[0] = 32'h0000_0100; dcnt[0] = 16'd512; deot[0] = 1'b1;
    run(32'h0000_F000, 1'b1, 8'd1, 32'd77, 2'd0, 512, 1, "R1 restart after abort");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule